// File: doc/BRIEF.md
# Serial Boot Download Controller

This block runs the byte-level conversation of a serial boot loader. It sits between a UART's receive and transmit byte streams, both with valid/ready handshakes, and a byte-wide memory write port. Out of reset it sends an announcement frame. It then waits for a host to answer with a fixed handshake. Each handshake byte must arrive within a tick limit, and any wrong byte, missing byte or too many zero bytes makes the block give up.

After the handshake the block accepts one image frame: a start marker, a big-endian 16-bit length, the payload and an XOR check byte. Payload bytes go to consecutive addresses from a fixed load address. A good check byte produces an acknowledge frame and a one-cycle start request that carries the load address and the initial stack value. A bad check byte produces an error frame. Giving up, by any path, raises a sticky abort output that a fallback path can use.

Every transmitted frame has seven bytes: 1B F6 02 00, then a kind byte, a code byte, and the XOR of the kind and code bytes.

Top module: `boot_dl_ctrl`

## Requirements
- R1: After reset the block transmits 1B F6 02 00 41 01 40 in that order. Each byte stays on tx_data with tx_valid high until tx_ready accepts it, and rx_ready is low whenever tx_valid is high.
- R2: tx_data and tx_valid do not change while a byte is offered and not yet accepted.
- R3: While waiting for the first handshake byte, every received byte other than 0x1B is discarded without effect. Each 0x00 counts toward ZERO_LIMIT, and the ZERO_LIMIT-th 0x00 causes an abort.
- R4: The waits for 0x1B and 0xF6 abort after LONG_TICKS cycles with no accepted byte. The later handshake waits abort after SHORT_TICKS cycles. Every accepted byte restarts the count.
- R5: After 0x1B the bytes F6, 02, 00, 52, 01 must follow in order; any other byte aborts.
- R6: After 01 one more byte is taken, and then 1B F6 02 00 41 02 43 is transmitted. If that byte was 0x53 the download stage follows; otherwise the block waits for 01 again under the short limit.
- R7: In the download stage there is no time limit. Bytes are discarded until 0x02. The next two bytes give the length, high byte first, and that many payload bytes are written to LOAD_ADDR, LOAD_ADDR+1, and so on, one mem_we pulse per byte.
- R8: The check value starts at 0x02 and is XORed with both length bytes and every payload byte. If the byte after the payload equals it, the block transmits 1B F6 02 00 41 03 42 and then raises start_pulse for exactly one cycle, with start_addr = LOAD_ADDR and start_stack = STACK_TOP.
- R9: If the check byte differs, the block transmits 1B F6 02 00 45 53 16 and then aborts, and start_pulse never rises.
- R10: A length of zero makes the next byte the check byte, with no memory write.
- R11: Once abort is high it stays high until reset. rx_ready then stays low and no further byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block accepts a received byte this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| mem_we | output | 1 | Payload byte write strobe |
| mem_addr | output | ADDR_W | Payload byte address |
| mem_wdata | output | 8 | Payload byte |
| start_pulse | output | 1 | One-cycle request to start the loaded image |
| start_addr | output | ADDR_W | Entry address of the loaded image |
| start_stack | output | ADDR_W | Initial stack value for the loaded image |
| abort | output | 1 | Sticky give-up indication |

## Verification
The hardest situations to reach from the ports are the exact edges of the timeout windows and the path back to waiting for 01 after a wrong final handshake byte. The first is reached by building the block with small tick limits, measuring the number of cycles from the last accepted byte and checking abort just inside and just outside each window. Spaced junk bytes, each gap shorter than the limit but all of them together much longer, show that every accepted byte restarts the count. The retry path is driven by ending the handshake with a wrong byte, checking that the reply frame still comes out, and then finishing the handshake correctly and completing a download.

// File: rtl/boot_dl_pkg.sv
package boot_dl_pkg;

   typedef enum logic [4:0] {
      ST_ANNOUNCE, ST_WAIT_ESC, ST_WAIT_F6, ST_WAIT_02, ST_WAIT_00,
      ST_WAIT_52,  ST_WAIT_01,  ST_WAIT_FIN, ST_REPLY,   ST_DL_SYNC,
      ST_LEN_HI,   ST_LEN_LO,   ST_PAYLOAD,  ST_CHECK,   ST_ACK,
      ST_NAK,      ST_LAUNCH,   ST_IDLE,     ST_ABORT
   } dl_state_t;

   localparam int unsigned FRAME_BYTES = 7;

   localparam logic [7:0] KIND_OK  = 8'h41;
   localparam logic [7:0] KIND_ERR = 8'h45;
   localparam logic [7:0] CODE_HELLO = 8'h01;
   localparam logic [7:0] CODE_REPLY = 8'h02;
   localparam logic [7:0] CODE_DONE  = 8'h03;
   localparam logic [7:0] CODE_BAD   = 8'h53;

   // Seven-byte frame: fixed four-byte head, kind, code, kind^code.
   function automatic logic [7:0] frame_byte(input logic [2:0] idx,
                                             input logic [7:0] kind,
                                             input logic [7:0] code);
      case (idx)
         3'd0:    frame_byte = 8'h1B;
         3'd1:    frame_byte = 8'hF6;
         3'd2:    frame_byte = 8'h02;
         3'd3:    frame_byte = 8'h00;
         3'd4:    frame_byte = kind;
         3'd5:    frame_byte = code;
         default: frame_byte = kind ^ code;
      endcase
   endfunction

endpackage

// File: rtl/boot_frame_tx.sv
module boot_frame_tx
   import boot_dl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] kind,
   input  logic [7:0] code,
   output logic [7:0] tx_data,
   output logic       tx_valid,
   input  logic       tx_ready,
   output logic       busy,
   output logic       done
);
   localparam logic [2:0] LAST_IDX = 3'(FRAME_BYTES - 1);

   logic [2:0] idx_q;
   logic [7:0] kind_q, code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx_q  <= '0;
         kind_q <= '0;
         code_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            idx_q  <= '0;
            kind_q <= kind;
            code_q <= code;
         end
      end else if (tx_ready) begin
         if (idx_q == LAST_IDX) busy <= 1'b0;
         else                   idx_q <= idx_q + 3'd1;
      end
   end

   assign tx_valid = busy;
   assign tx_data  = frame_byte(idx_q, kind_q, code_q);
   assign done     = busy && tx_ready && (idx_q == LAST_IDX);

   a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/boot_timeout.sv
module boot_timeout #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '1;
      else if (reload)                   cnt_q <= load_val;
      else if (run && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
   end

   assign expired = run && (cnt_q == '0);

   a_r4_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && load_val != '0) |=> !expired);

endmodule

// File: rtl/boot_dl_ctrl.sv
module boot_dl_ctrl
   import boot_dl_pkg::*;
#(
   parameter int unsigned      LONG_TICKS  = 32'h40000,
   parameter int unsigned      SHORT_TICKS = 32'h10000,
   parameter int unsigned      ZERO_LIMIT  = 100,
   parameter int unsigned      ADDR_W      = 24,
   parameter logic [ADDR_W-1:0] LOAD_ADDR  = 24'h800100,
   parameter logic [ADDR_W-1:0] STACK_TOP  = 24'h803FFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] start_stack,
   output logic              abort
);
   localparam int unsigned TMR_W = $clog2(LONG_TICKS + 1);
   localparam int unsigned ZC_W  = $clog2(ZERO_LIMIT + 1);
   localparam logic [TMR_W-1:0] LONG_LD  = TMR_W'(LONG_TICKS - 1);
   localparam logic [TMR_W-1:0] SHORT_LD = TMR_W'(SHORT_TICKS - 1);

   if (SHORT_TICKS < 2) begin : g_bad_short
      $error("SHORT_TICKS must be at least 2");
   end
   if (LONG_TICKS < SHORT_TICKS) begin : g_bad_long
      $error("LONG_TICKS must not be below SHORT_TICKS");
   end
   if (ZERO_LIMIT < 1) begin : g_bad_zero
      $error("ZERO_LIMIT must be at least 1");
   end
   if (ADDR_W < 17) begin : g_bad_addr
      $error("ADDR_W must hold a 16-bit offset");
   end

   dl_state_t state_q, state_d;

   logic            acc;
   logic            timed;
   logic            tmr_expired;
   logic            tmr_reload;
   logic [TMR_W-1:0] tmr_load;
   logic            tx_busy, tx_done, tx_start;
   logic [7:0]      fr_kind, fr_code;
   logic [ZC_W-1:0] zeros_q;
   logic [7:0]      fin_q, len_hi_q, csum_q;
   logic [15:0]     remain_q;
   logic [ADDR_W-1:0] ptr_q;
   logic            is_tx_state;

   assign acc = rx_valid && rx_ready;

   always_comb begin
      timed = 1'b0;
      case (state_q)
         ST_WAIT_ESC, ST_WAIT_F6, ST_WAIT_02, ST_WAIT_00,
         ST_WAIT_52, ST_WAIT_01, ST_WAIT_FIN: timed = 1'b1;
         default: timed = 1'b0;
      endcase
   end

   assign rx_ready = timed || state_q == ST_DL_SYNC || state_q == ST_LEN_HI ||
                     state_q == ST_LEN_LO || state_q == ST_PAYLOAD ||
                     state_q == ST_CHECK;

   // Frame selection per transmitting state.
   always_comb begin
      is_tx_state = 1'b1;
      fr_kind     = KIND_OK;
      fr_code     = CODE_HELLO;
      case (state_q)
         ST_ANNOUNCE: fr_code = CODE_HELLO;
         ST_REPLY:    fr_code = CODE_REPLY;
         ST_ACK:      fr_code = CODE_DONE;
         ST_NAK: begin
            fr_kind = KIND_ERR;
            fr_code = CODE_BAD;
         end
         default:     is_tx_state = 1'b0;
      endcase
   end
   assign tx_start = is_tx_state && !tx_busy;

   // Next-state logic.
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_ANNOUNCE: if (tx_done) state_d = ST_WAIT_ESC;
         ST_WAIT_ESC: begin
            if (acc) begin
               if (rx_data == 8'h1B) state_d = ST_WAIT_F6;
               else if (rx_data == 8'h00 && zeros_q == ZC_W'(1)) state_d = ST_ABORT;
            end else if (tmr_expired) state_d = ST_ABORT;
         end
         ST_WAIT_F6:  if (acc) state_d = (rx_data == 8'hF6) ? ST_WAIT_02 : ST_ABORT;
                      else if (tmr_expired) state_d = ST_ABORT;
         ST_WAIT_02:  if (acc) state_d = (rx_data == 8'h02) ? ST_WAIT_00 : ST_ABORT;
                      else if (tmr_expired) state_d = ST_ABORT;
         ST_WAIT_00:  if (acc) state_d = (rx_data == 8'h00) ? ST_WAIT_52 : ST_ABORT;
                      else if (tmr_expired) state_d = ST_ABORT;
         ST_WAIT_52:  if (acc) state_d = (rx_data == 8'h52) ? ST_WAIT_01 : ST_ABORT;
                      else if (tmr_expired) state_d = ST_ABORT;
         ST_WAIT_01:  if (acc) state_d = (rx_data == 8'h01) ? ST_WAIT_FIN : ST_ABORT;
                      else if (tmr_expired) state_d = ST_ABORT;
         ST_WAIT_FIN: if (acc) state_d = ST_REPLY;
                      else if (tmr_expired) state_d = ST_ABORT;
         ST_REPLY:    if (tx_done) state_d = (fin_q == 8'h53) ? ST_DL_SYNC : ST_WAIT_01;
         ST_DL_SYNC:  if (acc && rx_data == 8'h02) state_d = ST_LEN_HI;
         ST_LEN_HI:   if (acc) state_d = ST_LEN_LO;
         ST_LEN_LO:   if (acc) state_d = ({len_hi_q, rx_data} == 16'd0) ? ST_CHECK : ST_PAYLOAD;
         ST_PAYLOAD:  if (acc && remain_q == 16'd1) state_d = ST_CHECK;
         ST_CHECK:    if (acc) state_d = (rx_data == csum_q) ? ST_ACK : ST_NAK;
         ST_ACK:      if (tx_done) state_d = ST_LAUNCH;
         ST_NAK:      if (tx_done) state_d = ST_ABORT;
         ST_LAUNCH:   state_d = ST_IDLE;
         ST_IDLE:     state_d = ST_IDLE;
         default:     state_d = ST_ABORT;
      endcase
   end

   assign tmr_reload = acc || (state_d != state_q);
   assign tmr_load   = (state_d == ST_WAIT_ESC || state_d == ST_WAIT_F6) ? LONG_LD : SHORT_LD;

   // Datapath registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_ANNOUNCE;
         zeros_q   <= ZC_W'(ZERO_LIMIT);
         fin_q     <= '0;
         len_hi_q  <= '0;
         csum_q    <= '0;
         remain_q  <= '0;
         ptr_q     <= LOAD_ADDR;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         state_q <= state_d;
         mem_we  <= 1'b0;
         if (acc) begin
            case (state_q)
               ST_WAIT_ESC: if (rx_data == 8'h00) zeros_q <= zeros_q - 1'b1;
               ST_WAIT_FIN: fin_q <= rx_data;
               ST_DL_SYNC:  csum_q <= 8'h02;
               ST_LEN_HI: begin
                  len_hi_q <= rx_data;
                  csum_q   <= csum_q ^ rx_data;
               end
               ST_LEN_LO: begin
                  remain_q <= {len_hi_q, rx_data};
                  csum_q   <= csum_q ^ rx_data;
                  ptr_q    <= LOAD_ADDR;
               end
               ST_PAYLOAD: begin
                  mem_we    <= 1'b1;
                  mem_addr  <= ptr_q;
                  mem_wdata <= rx_data;
                  ptr_q     <= ptr_q + 1'b1;
                  remain_q  <= remain_q - 16'd1;
                  csum_q    <= csum_q ^ rx_data;
               end
               default: ;
            endcase
         end
      end
   end

   boot_frame_tx u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tx_start),
      .kind     (fr_kind),
      .code     (fr_code),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .busy     (tx_busy),
      .done     (tx_done)
   );

   boot_timeout #(.CNT_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (tmr_reload),
      .load_val (tmr_load),
      .run      (timed),
      .expired  (tmr_expired)
   );

   assign start_pulse = (state_q == ST_LAUNCH);
   assign start_addr  = LOAD_ADDR;
   assign start_stack = STACK_TOP;
   assign abort       = (state_q == ST_ABORT);

   a_r1_no_rx_during_tx: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);
   a_r11_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> abort);
   a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (!rx_ready && !tx_valid && !start_pulse));
   a_r8_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> (!start_pulse && !rx_ready));
   a_r7_write_in_download: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (!abort && !start_pulse && !tx_valid));

endmodule

// File: tb/tb_boot_dl_ctrl.sv
module tb_boot_dl_ctrl;
   localparam int unsigned LT = 40;
   localparam int unsigned ST = 24;
   localparam int unsigned ZL = 5;
   localparam logic [23:0] LA = 24'h800100;
   localparam logic [23:0] SP = 24'h803FFC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] rx_data = '0;
   logic rx_valid = 1'b0;
   logic rx_ready;
   logic [7:0] tx_data;
   logic tx_valid;
   logic tx_ready = 1'b0;
   logic mem_we;
   logic [23:0] mem_addr, start_addr, start_stack;
   logic [7:0] mem_wdata;
   logic start_pulse, abort;

   always #10 clk = ~clk;

   boot_dl_ctrl #(.LONG_TICKS(LT), .SHORT_TICKS(ST), .ZERO_LIMIT(ZL),
                  .ADDR_W(24), .LOAD_ADDR(LA), .STACK_TOP(SP)) dut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .start_pulse(start_pulse),
      .start_addr(start_addr), .start_stack(start_stack), .abort(abort));

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   logic [7:0]  txlog [0:255];
   logic [7:0]  wdat  [0:255];
   logic [23:0] wadr  [0:255];
   int tx_cnt = 0, w_cnt = 0, s_cnt = 0;
   logic [23:0] s_addr, s_stack;
   int tx_rd, w_base, s_base;

   always @(negedge clk) begin
      cyc++;
      tx_ready = (cyc % 3) != 0;
   end

   always @(posedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         txlog[tx_cnt % 256] = tx_data;
         tx_cnt++;
      end
      if (rst_n && mem_we) begin
         wdat[w_cnt % 256] = mem_wdata;
         wadr[w_cnt % 256] = mem_addr;
         w_cnt++;
      end
      if (rst_n && start_pulse) begin
         s_addr  = start_addr;
         s_stack = start_stack;
         s_cnt++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rx_valid = 1'b0;
      repeat (3) @(negedge clk);
      tx_rd = tx_cnt; w_base = w_cnt; s_base = s_cnt;
      rst_n = 1'b1;
   endtask

   task automatic wait_tx(input int n);
      for (int g = 0; g < 3000 && tx_cnt < n; g++) @(negedge clk);
   endtask

   task automatic expect_frame(input string req, input logic [7:0] k, input logic [7:0] c);
      logic [7:0] exp [0:6];
      exp[0] = 8'h1B; exp[1] = 8'hF6; exp[2] = 8'h02; exp[3] = 8'h00;
      exp[4] = k; exp[5] = c; exp[6] = k ^ c;
      wait_tx(tx_rd + 7);
      chk(req, (tx_cnt >= tx_rd + 7) ? 1 : 0, 1);
      for (int i = 0; i < 7; i++) chk(req, {24'h0, txlog[(tx_rd + i) % 256]}, {24'h0, exp[i]});
      tx_rd += 7;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit taken);
      taken = 1'b0;
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      for (int g = 0; g < 200; g++) begin
         @(posedge clk);
         if (rx_ready) begin
            taken = 1'b1;
            break;
         end
      end
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic put(input logic [7:0] b);
      bit t;
      send_byte(b, t);
   endtask

   task automatic handshake(input logic [7:0] fin);
      put(8'h1B); put(8'hF6); put(8'h02); put(8'h00); put(8'h52); put(8'h01); put(fin);
   endtask

   function automatic logic [7:0] pay(input int i, input int len);
      return 8'((i * 37 + len * 11 + 5) & 255);
   endfunction

   task automatic download(input int len, input logic [7:0] spoil);
      logic [7:0] cs;
      cs = 8'h02 ^ 8'(len >> 8) ^ 8'(len & 255);
      put(8'h02); put(8'(len >> 8)); put(8'(len & 255));
      for (int i = 0; i < len; i++) begin
         put(pay(i, len));
         cs ^= pay(i, len);
      end
      put(cs ^ spoil);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit t;
      int lens [0:4];
      lens[0] = 0; lens[1] = 1; lens[2] = 2; lens[3] = 3; lens[4] = 7;

      // Reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 reset abort", {31'h0, abort}, 0);
      chk("R8 reset start", {31'h0, start_pulse}, 0);
      chk("R1 reset tx_valid", {31'h0, tx_valid}, 0);
      chk("R7 reset mem_we", {31'h0, mem_we}, 0);

      // Length sweep through full good downloads
      for (int li = 0; li < 5; li++) begin
         do_reset();
         expect_frame("R1 announce", 8'h41, 8'h01);
         put(8'h33); put(8'h00); put(8'hA5);           // R3 ignored bytes
         handshake(8'h53);
         expect_frame("R6 reply", 8'h41, 8'h02);
         put(8'h99); put(8'h1B);                       // R7 discarded before marker
         download(lens[li], 8'h00);
         expect_frame("R8 ack", 8'h41, 8'h03);
         repeat (4) @(negedge clk);
         chk("R8 one start", s_cnt - s_base, 1);
         chk("R8 start addr", {8'h0, s_addr}, {8'h0, LA});
         chk("R8 start stack", {8'h0, s_stack}, {8'h0, SP});
         chk("R7 R10 write count", w_cnt - w_base, lens[li]);
         for (int i = 0; i < lens[li]; i++) begin
            chk("R7 write addr", {8'h0, wadr[(w_base + i) % 256]}, {8'h0, LA + 24'(i)});
            chk("R7 write data", {24'h0, wdat[(w_base + i) % 256]}, {24'h0, pay(i, lens[li])});
         end
         chk("R8 no abort", {31'h0, abort}, 0);
         chk("R8 rx closed", {31'h0, rx_ready}, 0);
      end

      // R6 retry after a wrong final byte
      do_reset();
      expect_frame("R1 announce", 8'h41, 8'h01);
      handshake(8'h77);
      expect_frame("R6 reply before judging", 8'h41, 8'h02);
      repeat (2) @(negedge clk);
      chk("R6 no abort on retry", {31'h0, abort}, 0);
      put(8'h01); put(8'h53);
      expect_frame("R6 second reply", 8'h41, 8'h02);
      download(2, 8'h00);
      expect_frame("R6 ack after retry", 8'h41, 8'h03);
      repeat (3) @(negedge clk);
      chk("R6 start after retry", s_cnt - s_base, 1);

      // R9 bad check byte, then R11 sticky
      do_reset();
      expect_frame("R1 announce", 8'h41, 8'h01);
      handshake(8'h53);
      expect_frame("R6 reply", 8'h41, 8'h02);
      download(3, 8'h5A);
      expect_frame("R9 error frame", 8'h45, 8'h53);
      repeat (3) @(negedge clk);
      chk("R9 abort", {31'h0, abort}, 1);
      chk("R9 no start", s_cnt - s_base, 0);
      send_byte(8'h1B, t);
      chk("R11 byte refused", {31'h0, t}, 0);
      chk("R11 abort held", {31'h0, abort}, 1);
      chk("R11 no tx after abort", tx_cnt - tx_rd, 0);

      // R3 zero count limit
      do_reset();
      expect_frame("R1 announce", 8'h41, 8'h01);
      for (int i = 0; i < ZL - 1; i++) put(8'h00);
      put(8'h55);
      repeat (2) @(negedge clk);
      chk("R3 below zero limit", {31'h0, abort}, 0);
      put(8'h00);
      repeat (2) @(negedge clk);
      chk("R3 zero limit reached", {31'h0, abort}, 1);

      // R4 reload on accepted bytes, then long timeout edge
      do_reset();
      expect_frame("R1 announce", 8'h41, 8'h01);
      for (int i = 0; i < 4; i++) begin
         repeat (LT - 12) @(negedge clk);
         put(8'h44);
      end
      chk("R4 reload keeps alive", {31'h0, abort}, 0);
      repeat (LT - 3) @(negedge clk);
      chk("R4 long window inside", {31'h0, abort}, 0);
      repeat (5) @(negedge clk);
      chk("R4 long window expired", {31'h0, abort}, 1);

      // R4 long limit for F6, short limit later
      do_reset();
      expect_frame("R1 announce", 8'h41, 8'h01);
      put(8'h1B);
      repeat (ST + 4) @(negedge clk);
      chk("R4 F6 uses long limit", {31'h0, abort}, 0);
      put(8'hF6); put(8'h02); put(8'h00); put(8'h52);
      repeat (ST - 3) @(negedge clk);
      chk("R4 short window inside", {31'h0, abort}, 0);
      repeat (5) @(negedge clk);
      chk("R4 short window expired", {31'h0, abort}, 1);

      // R5 wrong handshake byte
      do_reset();
      expect_frame("R1 announce", 8'h41, 8'h01);
      put(8'h1B); put(8'hF6); put(8'h03);
      repeat (2) @(negedge clk);
      chk("R5 wrong byte aborts", {31'h0, abort}, 1);
      chk("R5 no reply", tx_cnt - tx_rd, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule